// File: doc/BRIEF.md
# Compare-Driven PWM Channel Cell

This block is a single PWM cell. A free-running up-counter steps from a programmable start value to a programmable end value and then restarts. Six compare values place events inside that period. Three pairs of compare values set and clear the three waveform outputs: the main A output, the main B output and an auxiliary X output. The X output also serves as the cell's own sync reference. A one-clock half-period strobe and two one-clock trigger lines are also produced, and the trigger lines are meant to start conversions in an ADC sequencer.

Software writes every setting through one narrow write port into shadow copies. All shadow copies move into the working set together on the clock edge where the counter wraps, so each period runs on one consistent set of values. Per-compare enable bits choose which matches reach the trigger lines. Each waveform output has its own inversion bit.

Top module: `pwm_cell`

## Requirements
- R1: After reset, `count` steps up by one per clock until it equals cmp1. On the next edge it loads the start value, so the period is cmp1 − start + 1 clocks.
- R2: Writes land in shadow registers, and all shadow registers are copied into the working set on the wrap edge. A write made mid-period does not change the current period's end point.
- R3: All waveform outputs are registered, so an output changes on the edge after `count` holds the matching value. A cmp2 match drives raw A high and a cmp3 match drives it low. When both match at once, low wins.
- R4: A cmp4 match drives raw B high and a cmp5 match drives it low. When both match at once, low wins.
- R5: A cmp0 match drives raw X high and a cmp1 match drives it low. When both match at once, low wins.
- R6: `local_sync` goes high after a cmp1 match and low after a cmp0 match. If both match at once, high wins.
- R7: `half_rld` is high for exactly one clock after each cycle in which `count` equals cmp0.
- R8: Control bit n (n = 0..5) lets a cmpn match raise a trigger. Enabled even-index matches pulse `trig_even` and enabled odd-index matches pulse `trig_odd`, each one clock wide and registered like the waveforms.
- R9: A match whose enable bit is clear raises no trigger, even when several compare registers hold the same value as an enabled one.
- R10: Control bits 6, 7 and 8 invert `pwm_a`, `pwm_b` and `pwm_x` respectively after the set/clear logic. The inversion is taken from the working set.
- R11: During and right after reset, `count` is 0, the start and compare values and control word are 0, and every output is 0.
- R12: The write address selects the target: 0..5 = cmp0..cmp5, 6 = start value, 7 = control word (bits 5:0 trigger enables, bits 8:6 inversion).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Shadow register write strobe |
| wr_addr | input | 3 | Shadow register select |
| wr_data | input | CW (16) | Write data |
| pwm_a | output | 1 | A waveform after inversion |
| pwm_b | output | 1 | B waveform after inversion |
| pwm_x | output | 1 | Auxiliary X waveform after inversion |
| local_sync | output | 1 | Cell sync level |
| half_rld | output | 1 | Half-period strobe |
| trig_even | output | 1 | Trigger pulse from enabled cmp0/2/4 |
| trig_odd | output | 1 | Trigger pulse from enabled cmp1/3/5 |
| count | output | CW (16) | Period counter |

## Verification
The bench uses equal set and clear values. A design that let set win would hold A high when it should stay low. It loads three compare registers with one value and enables only one odd compare. A design that ignored the enable bits, or mixed up the even and odd lines, would add pulses to the wrong trigger line. It shortens the period with a write in the middle of a period. A design without shadowing would wrap early, at the new end value. Inverted outputs are checked both before and after the control word switches, to catch inversion applied out of step with the working set.

// File: rtl/pwm_cell_pkg.sv
package pwm_cell_pkg;
  localparam int NVAL     = 6;
  localparam int NCH      = 3;
  localparam int AW       = 3;
  localparam int ADDR_INI = NVAL;
  localparam int ADDR_CTL = NVAL + 1;
  localparam int POL_LSB  = NVAL;
  localparam int CTLW     = NVAL + NCH;

  // channel 0 = A (cmp2/cmp3), 1 = B (cmp4/cmp5), 2 = X (cmp0/cmp1)
  function automatic int set_idx(input int ch);
    return (ch == NCH - 1) ? 0 : 2 * ch + 2;
  endfunction
endpackage

// File: rtl/pwm_cell_regs.sv
module pwm_cell_regs
  import pwm_cell_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [CW-1:0]            wr_data,
  input  logic                     load,
  output logic [NVAL-1:0][CW-1:0]  val_act,
  output logic [CW-1:0]            init_act,
  output logic [CW-1:0]            init_shd,
  output logic [NVAL-1:0]          en_act,
  output logic [NCH-1:0]           pol_nxt
);
  logic [NVAL-1:0][CW-1:0] val_shd;
  logic [CTLW-1:0]         ctl_shd;
  logic [CTLW-1:0]         ctl_act;

  for (genvar i = 0; i < NVAL; i++) begin : g_val
    always_ff @(posedge clk) begin
      if (rst) begin
        val_shd[i] <= '0;
        val_act[i] <= '0;
      end else begin
        if (wr_en && wr_addr == AW'(i)) val_shd[i] <= wr_data;
        if (load) val_act[i] <= val_shd[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      init_shd <= '0;
      init_act <= '0;
      ctl_shd  <= '0;
      ctl_act  <= '0;
    end else begin
      if (wr_en && wr_addr == AW'(ADDR_INI)) init_shd <= wr_data;
      if (wr_en && wr_addr == AW'(ADDR_CTL)) ctl_shd  <= wr_data[CTLW-1:0];
      if (load) begin
        init_act <= init_shd;
        ctl_act  <= ctl_shd;
      end
    end
  end

  assign en_act  = ctl_act[NVAL-1:0];
  assign pol_nxt = load ? ctl_shd[POL_LSB +: NCH] : ctl_act[POL_LSB +: NCH];
endmodule

// File: rtl/pwm_cell_cmp.sv
module pwm_cell_cmp
  import pwm_cell_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic [CW-1:0]           cnt,
  input  logic [NVAL-1:0][CW-1:0] val,
  output logic [NVAL-1:0]         match
);
  for (genvar i = 0; i < NVAL; i++) begin : g_eq
    assign match[i] = (cnt == val[i]);
  end
endmodule

// File: rtl/pwm_cell_out.sv
module pwm_cell_out
  import pwm_cell_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NVAL-1:0] match,
  input  logic [NVAL-1:0] en,
  input  logic [NCH-1:0]  pol_nxt,
  output logic [NCH-1:0]  raw,
  output logic [NCH-1:0]  pin,
  output logic            sync,
  output logic            half,
  output logic            trig_e,
  output logic            trig_o
);
  logic [NCH-1:0]  raw_d;
  logic [NVAL-1:0] hit;
  logic            te_d;
  logic            to_d;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int SI = set_idx(c);
    localparam int CI = SI + 1;
    assign raw_d[c] = match[CI] ? 1'b0 : (match[SI] ? 1'b1 : raw[c]);
  end

  assign hit = match & en;

  always_comb begin
    te_d = 1'b0;
    to_d = 1'b0;
    for (int i = 0; i < NVAL; i++) begin
      if (i % 2 == 0) te_d = te_d | hit[i];
      else            to_d = to_d | hit[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw    <= '0;
      pin    <= '0;
      sync   <= 1'b0;
      half   <= 1'b0;
      trig_e <= 1'b0;
      trig_o <= 1'b0;
    end else begin
      raw    <= raw_d;
      pin    <= raw_d ^ pol_nxt;
      sync   <= match[1] ? 1'b1 : (match[0] ? 1'b0 : sync);
      half   <= match[0];
      trig_e <= te_d;
      trig_o <= to_d;
    end
  end
endmodule

// File: rtl/pwm_cell.sv
module pwm_cell
  import pwm_cell_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic          pwm_a,
  output logic          pwm_b,
  output logic          pwm_x,
  output logic          local_sync,
  output logic          half_rld,
  output logic          trig_even,
  output logic          trig_odd,
  output logic [CW-1:0] count
);
  logic [CW-1:0]           cnt_q;
  logic [NVAL-1:0][CW-1:0] val_act;
  logic [CW-1:0]           init_act;
  logic [CW-1:0]           init_shd;
  logic [NVAL-1:0]         en_act;
  logic [NCH-1:0]          pol_nxt;
  logic [NVAL-1:0]         match;
  logic [NCH-1:0]          raw_q;
  logic [NCH-1:0]          pin_q;
  logic                    wrap;

  assign wrap = match[1];

  pwm_cell_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .load(wrap), .val_act(val_act), .init_act(init_act), .init_shd(init_shd),
    .en_act(en_act), .pol_nxt(pol_nxt)
  );

  pwm_cell_cmp #(.CW(CW)) u_cmp (
    .cnt(cnt_q), .val(val_act), .match(match)
  );

  pwm_cell_out u_out (
    .clk(clk), .rst(rst), .match(match), .en(en_act), .pol_nxt(pol_nxt),
    .raw(raw_q), .pin(pin_q), .sync(local_sync), .half(half_rld),
    .trig_e(trig_even), .trig_o(trig_odd)
  );

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (wrap) cnt_q <= init_shd;
    else           cnt_q <= cnt_q + 1'b1;
  end

  assign count = cnt_q;
  assign pwm_a = pin_q[0];
  assign pwm_b = pin_q[1];
  assign pwm_x = pin_q[2];
endmodule

// File: rtl/pwm_cell_chk.sv
module pwm_cell_chk
  import pwm_cell_pkg::*;
#(
  parameter int CW = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic [CW-1:0]            cnt,
  input logic [NVAL-1:0][CW-1:0]  val,
  input logic [CW-1:0]            init,
  input logic [NVAL-1:0]          en,
  input logic [NCH-1:0]           raw,
  input logic                     trig_e,
  input logic                     trig_o,
  input logic                     half
);
  a_r1_step: assert property (@(posedge clk) disable iff (rst)
    (cnt != val[1]) |=> (cnt == $past(cnt) + 1'b1));

  a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
    (cnt == val[1]) |=> (cnt == init));

  a_r3_clear_wins: assert property (@(posedge clk) disable iff (rst)
    (cnt == val[3]) |=> !raw[0]);

  a_r5_x_clear: assert property (@(posedge clk) disable iff (rst)
    (cnt == val[1]) |=> !raw[2]);

  a_r7_half_origin: assert property (@(posedge clk) disable iff (rst)
    half |-> ($past(cnt) == $past(val[0])));

  a_r9_no_enable_no_trig: assert property (@(posedge clk) disable iff (rst)
    (en == '0) |=> (!trig_e && !trig_o));
endmodule

bind pwm_cell pwm_cell_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .cnt(cnt_q), .val(val_act), .init(init_act),
  .en(en_act), .raw(raw_q), .trig_e(trig_even), .trig_o(trig_odd), .half(half_rld)
);

// File: tb/pwm_cell_tb.sv
module pwm_cell_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        pwm_a, pwm_b, pwm_x, local_sync, half_rld, trig_even, trig_odd;
  logic [15:0] count;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  bit live  = 0;

  always #5 clk = ~clk;

  pwm_cell #(.CW(16)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_a(pwm_a), .pwm_b(pwm_b), .pwm_x(pwm_x), .local_sync(local_sync),
    .half_rld(half_rld), .trig_even(trig_even), .trig_odd(trig_odd), .count(count)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  int m_shd[8];
  int m_act[8];
  int m_cnt;
  bit m_raw[3];
  bit m_out[3];
  bit m_sync, m_half, m_te, m_to;
  bit mt[6];
  int sets[3] = '{2, 4, 0};

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 8; i++) begin m_shd[i] = 0; m_act[i] = 0; end
      m_cnt = 0;
      for (int c = 0; c < 3; c++) begin m_raw[c] = 0; m_out[c] = 0; end
      m_sync = 0; m_half = 0; m_te = 0; m_to = 0;
    end else begin
      for (int i = 0; i < 6; i++) mt[i] = (m_cnt == m_act[i]);
      for (int c = 0; c < 3; c++) begin
        if (mt[sets[c] + 1])  m_raw[c] = 0;
        else if (mt[sets[c]]) m_raw[c] = 1;
      end
      if (mt[1])      m_sync = 1;
      else if (mt[0]) m_sync = 0;
      m_half = mt[0];
      m_te = 0; m_to = 0;
      for (int i = 0; i < 6; i++)
        if (mt[i] && m_act[7][i]) begin
          if (i % 2 == 0) m_te = 1; else m_to = 1;
        end
      if (mt[1]) begin
        m_cnt = m_shd[6];
        for (int i = 0; i < 8; i++) m_act[i] = m_shd[i];
      end else begin
        m_cnt = (m_cnt + 1) % 65536;
      end
      for (int c = 0; c < 3; c++) m_out[c] = m_raw[c] ^ m_act[7][6 + c];
      if (wr_en) m_shd[wr_addr] = int'(wr_data);
    end
  end

  always @(negedge clk) begin
    if (live && !rst) begin
      chk("R1 count",      int'(count),      m_cnt);
      chk("R3 pwm_a",      int'(pwm_a),      int'(m_out[0]));
      chk("R4 pwm_b",      int'(pwm_b),      int'(m_out[1]));
      chk("R5 pwm_x",      int'(pwm_x),      int'(m_out[2]));
      chk("R6 local_sync", int'(local_sync), int'(m_sync));
      chk("R7 half_rld",   int'(half_rld),   int'(m_half));
      chk("R8 trig_even",  int'(trig_even),  int'(m_te));
      chk("R8 trig_odd",   int'(trig_odd),   int'(m_to));
    end
  end

  // R12: address 0..5 cmp, 6 start, 7 control
  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = a[2:0]; wr_data = d[15:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cfg(input int ini, input int v0, input int v1, input int v2,
                     input int v3, input int v4, input int v5, input int ctl);
    wr(6, ini); wr(0, v0); wr(2, v2); wr(3, v3);
    wr(4, v4); wr(5, v5); wr(7, ctl); wr(1, v1);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int ne, no, hi, prev;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 count",  int'(count), 0);
    chk("R11 outputs", int'({pwm_a, pwm_b, pwm_x, local_sync, half_rld, trig_even, trig_odd}), 0);
    rst = 1'b0;
    live = 1;
    @(negedge clk);
    chk("R11 count after release", int'(count), 0);

    // main pattern, all triggers on
    cfg(0, 10, 19, 3, 8, 5, 15, 16'h03F);
    repeat (70) @(negedge clk);

    // R9: equal values, only cmp3 enabled on the odd line
    cfg(0, 7, 19, 7, 12, 7, 15, 16'h008);
    repeat (45) @(negedge clk);
    ne = 0; no = 0;
    for (int k = 0; k < 40; k++) begin
      ne += int'(trig_even); no += int'(trig_odd);
      @(negedge clk);
    end
    chk("R9 trig_even pulses with enables clear", ne, 0);
    chk("R8 trig_odd pulses from cmp3 only", no, 2);

    // R3 clear wins, R10 inversion on all outputs
    cfg(0, 4, 19, 9, 9, 2, 14, 16'h1C0 | 16'h004);
    repeat (45) @(negedge clk);
    hi = 0;
    for (int k = 0; k < 40; k++) begin
      hi += int'(pwm_a);
      @(negedge clk);
    end
    chk("R3 clear wins (inverted A always high)", hi, 40);
    chk("R12 ctl bit 8 inverts X at low phase", int'(pwm_x), int'(!m_raw[2]));

    // R2: mid-period shorten
    cfg(0, 3, 19, 2, 6, 4, 8, 16'h000);
    repeat (45) @(negedge clk);
    while (count != 16'd5) @(negedge clk);
    wr(1, 9);
    prev = int'(count);
    while (count != 16'd0) begin prev = int'(count); @(negedge clk); end
    chk("R2 old period end kept", prev, 19);
    @(negedge clk);
    while (count != 16'd0) begin prev = int'(count); @(negedge clk); end
    chk("R2 new period end", prev, 9);
    repeat (20) @(negedge clk);
    summary();
  end
endmodule